// File: doc/BRIEF.md
# Single-Channel DMA Engine with Grouped Source Reload

This block is one DMA channel. It moves 32-bit words from a peripheral data register to memory. Software writes a source start address, a destination start address, a transfer count and an addressing mode for each side, then pulses `start`. Each request from the peripheral opens a burst. During a burst the channel holds the bus and performs read/write pairs back to back.

When reload is selected, the source pointer returns to its start address after every fourth transfer. At the same point the burst ends and the bus is released, so the peripheral must request again for the next group. The destination pointer keeps stepping across these group boundaries. With reload off, one request drains the whole count in a single burst.

When the count is used up, the channel disables itself and sets a sticky interrupt flag. The flag reaches the `irq` pin only while the interrupt enable is set.

Top module: `dma_reload_chan`

## Requirements
- R1: After reset, `bus_req`, `rd_stb`, `wr_stb`, `chan_en` and `irq` are all low.
- R2: A `start` pulse while `chan_en` is low loads both start addresses and the count. It sets `chan_en` on the next edge only if the count is nonzero. A `start` while `chan_en` is high has no effect.
- R3: With the channel enabled and idle, `periph_req` raises `bus_req` in the next cycle. No strobe appears before `bus_gnt` has been seen high. `bus_req` stays high for every strobe of the burst.
- R4: Each transfer is one `rd_stb` cycle on the source address, followed directly by one `wr_stb` cycle on the destination address. During the write, `wdata` equals the `rdata` sampled in the read cycle.
- R5: Each address has its own 2-bit mode: code 01 adds 4 after each transfer, code 10 subtracts 4, and codes 00 and 11 hold the address.
- R6: With `cfg_reload` high, the source address of transfers 1, 5, 9, ... after a start is the programmed source start. The destination keeps stepping by its mode.
- R7: With `cfg_reload` high, the burst ends after the fourth transfer of each group: `bus_req` falls while `chan_en` stays high. A fresh `periph_req` is needed for the next group.
- R8: With `cfg_reload` low, one request performs every remaining transfer in one unbroken burst, and the source never wraps.
- R9: In the cycle after the last write, `chan_en` and `bus_req` are low and the interrupt flag is set. A final group shorter than four also ends here.
- R10: `irq` is the sticky flag gated by `cfg_ie`. `irq_clr` clears the flag, but a completion in the same cycle as `irq_clr` wins.
- R11: `periph_req` while `chan_en` is low causes no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src_start | input | ADDR_W | Source start address |
| cfg_dst_start | input | ADDR_W | Destination start address |
| cfg_count | input | CNT_W | Total number of transfers |
| cfg_src_mode | input | 2 | Source step mode (01 inc, 10 dec, else hold) |
| cfg_dst_mode | input | 2 | Destination step mode (01 inc, 10 dec, else hold) |
| cfg_reload | input | 1 | Source reload every four transfers |
| cfg_ie | input | 1 | Interrupt enable |
| start | input | 1 | Load configuration and enable the channel |
| irq_clr | input | 1 | Clear the interrupt flag |
| periph_req | input | 1 | Peripheral transfer request |
| bus_gnt | input | 1 | Bus grant |
| rdata | input | DATA_W | Read data from the source |
| bus_req | output | 1 | Bus request, high for the whole burst |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| bus_addr | output | ADDR_W | Address of the current strobe |
| wdata | output | DATA_W | Write data |
| chan_en | output | 1 | Channel enabled |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
The bench aims at the group boundary. A design that stepped the source instead of snapping it back would read the fifth word from start+16. One that kept the bus across the boundary would run a second group without a new request. It also runs a count of ten, so the last group has two transfers; a design that waited for a full group would never finish. Further checks cover a start pulse that arrives mid-run, which must not restart the pointers. The irq clear is held high during completion, where a design in which the clear wins would never show the interrupt. A delayed grant catches a read issued too early.

// File: rtl/dma_reload_pkg.sv
package dma_reload_pkg;

   typedef enum logic [1:0] {
      CH_IDLE     = 2'd0,
      CH_WAIT_GNT = 2'd1,
      CH_READ     = 2'd2,
      CH_WRITE    = 2'd3
   } ch_state_e;

   localparam logic [1:0] AM_HOLD = 2'b00;
   localparam logic [1:0] AM_INC  = 2'b01;
   localparam logic [1:0] AM_DEC  = 2'b10;

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
   import dma_reload_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [1:0]        mode,
   input  logic              advance,
   input  logic              reload,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] stepped;
   logic [ADDR_W-1:0] next_adv;

   always_comb begin
      case (mode)
         AM_INC:  stepped = addr_q + STEP_V;
         AM_DEC:  stepped = addr_q - STEP_V;
         default: stepped = addr_q;
      endcase
   end

   assign next_adv = reload ? base_q : stepped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         addr_q <= '0;
      end else if (load) begin
         base_q <= start_addr;
         addr_q <= start_addr;
      end else if (advance) begin
         addr_q <= next_adv;
      end
   end

   assign addr = addr_q;

   // R6
   reload_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && reload && !load) |=> (addr_q == base_q));

   // R5
   hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !reload && !load && (mode == AM_HOLD)) |=> $stable(addr_q));

endmodule

// File: rtl/dma_xfer_ctr.sv
module dma_xfer_ctr #(
   parameter int CNT_W = 16,
   parameter int GROUP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             advance,
   output logic             last,
   output logic             grp_end
);

   localparam int GRP_W = (GROUP > 2) ? $clog2(GROUP) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic [GRP_W-1:0] grp_q;
   logic [GRP_W-1:0] grp_next;

   generate
      if ((GROUP & (GROUP - 1)) == 0) begin : g_pow2
         assign grp_end  = &grp_q;
         assign grp_next = grp_q + GRP_W'(1);
      end else begin : g_any
         assign grp_end  = (grp_q == GRP_W'(GROUP - 1));
         assign grp_next = grp_end ? '0 : grp_q + GRP_W'(1);
      end
   endgenerate

   assign last = (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         grp_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
         grp_q <= '0;
      end else if (advance) begin
         cnt_q <= cnt_q - CNT_W'(1);
         grp_q <= grp_next;
      end
   end

   // R9
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> (cnt_q != '0));

   // R6
   group_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && grp_end && !load) |=> (grp_q == '0));

endmodule

// File: rtl/dma_irq_flag.sv
module dma_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic ie,
   output logic flag,
   output logic irq
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (set)
         flag_q <= 1'b1;
      else if (clr)
         flag_q <= 1'b0;
   end

   assign flag = flag_q;
   assign irq  = flag_q & ie;

   // R10
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q);

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag_q);

endmodule

// File: rtl/dma_reload_chan.sv
module dma_reload_chan
   import dma_reload_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int GROUP  = 4,
   parameter int STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_src_start,
   input  logic [ADDR_W-1:0] cfg_dst_start,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic [1:0]        cfg_src_mode,
   input  logic [1:0]        cfg_dst_mode,
   input  logic              cfg_reload,
   input  logic              cfg_ie,
   input  logic              start,
   input  logic              irq_clr,
   input  logic              periph_req,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] rdata,
   output logic              bus_req,
   output logic              rd_stb,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] wdata,
   output logic              chan_en,
   output logic              irq
);

   generate
      if (GROUP < 2) begin : g_bad_group
         $error("GROUP must be 2 or more");
      end
      if (STEP < 1) begin : g_bad_step
         $error("STEP must be positive");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be 2 or more");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must be 8 or more");
      end
   endgenerate

   ch_state_e         st_q;
   logic              en_q;
   logic [DATA_W-1:0] buf_q;
   logic              load;
   logic              advance;
   logic              last;
   logic              grp_end;
   logic              do_reload;
   logic              irq_flag;
   logic [ADDR_W-1:0] src_addr;
   logic [ADDR_W-1:0] dst_addr;

   assign load      = start && !en_q;
   assign advance   = (st_q == CH_WRITE);
   assign do_reload = cfg_reload && grp_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= CH_IDLE;
         buf_q <= '0;
      end else begin
         case (st_q)
            CH_IDLE:     if (en_q && periph_req) st_q <= CH_WAIT_GNT;
            CH_WAIT_GNT: if (bus_gnt) st_q <= CH_READ;
            CH_READ: begin
               buf_q <= rdata;
               st_q  <= CH_WRITE;
            end
            CH_WRITE: begin
               if (last || do_reload)
                  st_q <= CH_IDLE;
               else
                  st_q <= CH_READ;
            end
            default: st_q <= CH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (load)
         en_q <= (cfg_count != '0);
      else if (advance && last)
         en_q <= 1'b0;
   end

   dma_addr_gen #(.ADDR_W(ADDR_W), .STEP(STEP)) u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .start_addr (cfg_src_start),
      .mode       (cfg_src_mode),
      .advance    (advance),
      .reload     (do_reload),
      .addr       (src_addr)
   );

   dma_addr_gen #(.ADDR_W(ADDR_W), .STEP(STEP)) u_dst (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .start_addr (cfg_dst_start),
      .mode       (cfg_dst_mode),
      .advance    (advance),
      .reload     (1'b0),
      .addr       (dst_addr)
   );

   dma_xfer_ctr #(.CNT_W(CNT_W), .GROUP(GROUP)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (cfg_count),
      .advance  (advance),
      .last     (last),
      .grp_end  (grp_end)
   );

   dma_irq_flag u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (advance && last),
      .clr   (irq_clr),
      .ie    (cfg_ie),
      .flag  (irq_flag),
      .irq   (irq)
   );

   assign bus_req  = (st_q != CH_IDLE);
   assign rd_stb   = (st_q == CH_READ);
   assign wr_stb   = (st_q == CH_WRITE);
   assign bus_addr = (st_q == CH_WRITE) ? dst_addr : src_addr;
   assign wdata    = buf_q;
   assign chan_en  = en_q;

   // R3
   strobe_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb || wr_stb) |-> bus_req);

   // R3
   no_read_before_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == CH_WAIT_GNT) && !bus_gnt) |=> !rd_stb);

   // R4
   read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> wr_stb);

   // R4
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_stb, wr_stb}));

   // R9
   done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_en) |-> (irq_flag && !bus_req));

   // R11
   idle_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_en && !bus_req) |=> !bus_req);

endmodule

// File: tb/test_dma_reload_chan.sv
module test_dma_reload_chan;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] cfg_src_start, cfg_dst_start;
   logic [15:0] cfg_count;
   logic [1:0]  cfg_src_mode, cfg_dst_mode;
   logic        cfg_reload, cfg_ie, start, irq_clr, periph_req, bus_gnt;
   logic [31:0] rdata;
   logic        bus_req, rd_stb, wr_stb, chan_en, irq;
   logic [31:0] bus_addr, wdata;

   always #5 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit cmp_on = 1'b0;
   int rd_idx = 0;
   int gnt_lat = 0;
   int gw = 0;

   function automatic logic [31:0] rfn(logic [31:0] a);
      return {a[15:0], ~a[15:0]} ^ 32'h1234_5678;
   endfunction

   function automatic logic [31:0] stepf(logic [31:0] a, logic [1:0] m);
      if (m == 2'b01) return a + 32'd4;
      if (m == 2'b10) return a - 32'd4;
      return a;
   endfunction

   assign rdata = rfn(bus_addr);

   dma_reload_chan i_dma_reload_chan (
      .clk(clk), .rst_n(rst_n),
      .cfg_src_start(cfg_src_start), .cfg_dst_start(cfg_dst_start),
      .cfg_count(cfg_count), .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
      .cfg_reload(cfg_reload), .cfg_ie(cfg_ie), .start(start), .irq_clr(irq_clr),
      .periph_req(periph_req), .bus_gnt(bus_gnt), .rdata(rdata),
      .bus_req(bus_req), .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_addr(bus_addr),
      .wdata(wdata), .chan_en(chan_en), .irq(irq)
   );

   task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
      end
   endtask

   // behavioural reference model: 0 idle, 1 wait grant, 2 read, 3 write
   int          mst;
   int          mcnt, mgrp;
   bit          men, mflag;
   logic [31:0] msrc, mdst, mbase, mbuf;

   always @(posedge clk or negedge rst_n) begin
      int ost;
      bit oen;
      bit setf;
      if (!rst_n) begin
         mst = 0; mcnt = 0; mgrp = 0; men = 0; mflag = 0;
         msrc = 0; mdst = 0; mbase = 0; mbuf = 0;
      end else begin
         ost  = mst;
         oen  = men;
         setf = 0;
         case (ost)
            0: if (oen && periph_req) mst = 1;
            1: if (bus_gnt) mst = 2;
            2: begin mbuf = rfn(msrc); mst = 3; end
            default: begin
               msrc = (cfg_reload && mgrp == 3) ? mbase : stepf(msrc, cfg_src_mode);
               mdst = stepf(mdst, cfg_dst_mode);
               mcnt = mcnt - 1;
               mgrp = (mgrp == 3) ? 0 : mgrp + 1;
               if (mcnt == 0) begin
                  men = 0; setf = 1; mst = 0;
               end else if (cfg_reload && mgrp == 0) mst = 0;
               else mst = 2;
            end
         endcase
         if (start && !oen) begin
            mbase = cfg_src_start; msrc = cfg_src_start; mdst = cfg_dst_start;
            mcnt = int'(cfg_count); mgrp = 0; men = (cfg_count != 0);
         end
         if (setf) mflag = 1;
         else if (irq_clr) mflag = 0;
      end
   end

   // per-cycle comparison, away from the clock edge
   always @(posedge clk) begin
      #3;
      if (cmp_on) begin
         chk("R3", "bus_req", 32'(bus_req), 32'(mst != 0));
         chk("R4", "rd_stb", 32'(rd_stb), 32'(mst == 2));
         chk("R4", "wr_stb", 32'(wr_stb), 32'(mst == 3));
         if (mst == 2) begin
            chk("R5", "read addr", bus_addr, msrc);
            if (cfg_reload && (rd_idx % 4) == 0)
               chk("R6", "group first read addr", bus_addr, cfg_src_start);
            rd_idx++;
         end
         if (mst == 3) begin
            chk("R5", "write addr", bus_addr, mdst);
            chk("R4", "wdata", wdata, mbuf);
         end
         chk("R9", "chan_en", 32'(chan_en), 32'(men));
         chk("R10", "irq", 32'(irq), 32'(mflag && cfg_ie));
      end
   end

   // grant responder
   always @(negedge clk) begin
      if (!bus_req) begin
         gw = 0; bus_gnt = 1'b0;
      end else begin
         gw++;
         if (gw > gnt_lat) bus_gnt = 1'b1;
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_start();
      start = 1'b1; rd_idx = 0; cyc(1); start = 1'b0;
   endtask

   task automatic pulse_req();
      periph_req = 1'b1; cyc(1); periph_req = 1'b0;
   endtask

   task automatic run_burst();
      while (!bus_req) @(negedge clk);
      while (bus_req) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; bus_gnt = 1'b0;
      cfg_src_start = 0; cfg_dst_start = 0; cfg_count = 0;
      cfg_src_mode = 0; cfg_dst_mode = 0; cfg_reload = 0; cfg_ie = 0;
      start = 0; irq_clr = 0; periph_req = 0;
      cyc(3);
      chk("R1", "bus_req in reset", 32'(bus_req), 0);
      chk("R1", "strobes in reset", 32'({rd_stb, wr_stb}), 0);
      chk("R1", "chan_en in reset", 32'(chan_en), 0);
      chk("R1", "irq in reset", 32'(irq), 0);
      rst_n = 1'b1;
      cyc(1);
      cmp_on = 1'b1;

      // zero count must not enable
      pulse_start(); cyc(1);
      chk("R2", "chan_en after zero-count start", 32'(chan_en), 0);

      // request while disabled
      periph_req = 1'b1; cyc(3); periph_req = 1'b0;
      chk("R11", "bus_req with channel disabled", 32'(bus_req), 0);

      // reload on, src inc, dst dec, ten transfers (4,4,2), slow grant
      cfg_src_start = 32'h0400_0080; cfg_dst_start = 32'h0040_0000;
      cfg_count = 16'd10; cfg_src_mode = 2'b01; cfg_dst_mode = 2'b10;
      cfg_reload = 1'b1; cfg_ie = 1'b1; gnt_lat = 2;
      pulse_start();
      chk("R2", "chan_en after start", 32'(chan_en), 1);
      for (int g = 0; g < 3; g++) begin
         pulse_req();
         if (g == 1) begin
            start = 1'b1; cyc(1); start = 1'b0;
         end
         run_burst();
         if (g < 2) begin
            cyc(3);
            chk("R7", "bus released between groups", 32'(bus_req), 0);
            chk("R7", "channel still enabled between groups", 32'(chan_en), 1);
         end
      end
      chk("R2", "mid-run start ignored, total reads", 32'(rd_idx), 32'd10);
      chk("R9", "chan_en after final short group", 32'(chan_en), 0);
      chk("R10", "irq after completion", 32'(irq), 1);
      cyc(3);
      chk("R10", "irq sticky", 32'(irq), 1);
      irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
      chk("R10", "irq after clear", 32'(irq), 0);

      // reload off, src hold, dst inc, six transfers in one burst, clear held
      cfg_src_start = 32'h0000_1000; cfg_dst_start = 32'h0000_2000;
      cfg_count = 16'd6; cfg_src_mode = 2'b00; cfg_dst_mode = 2'b01;
      cfg_reload = 1'b0; gnt_lat = 0; irq_clr = 1'b1;
      pulse_start();
      pulse_req();
      run_burst();
      chk("R8", "reads in single burst", 32'(rd_idx), 32'd6);
      chk("R8", "chan_en after single burst", 32'(chan_en), 0);
      chk("R10", "set wins over clear", 32'(irq), 1);
      cyc(1);
      chk("R10", "held clear acts next cycle", 32'(irq), 0);
      irq_clr = 1'b0;

      // reload on, src mode 11 holds, dst dec, exactly one group, masked irq
      cfg_src_start = 32'h0000_3000; cfg_dst_start = 32'h0000_4000;
      cfg_count = 16'd4; cfg_src_mode = 2'b11; cfg_dst_mode = 2'b10;
      cfg_reload = 1'b1; cfg_ie = 1'b0;
      pulse_start();
      pulse_req();
      run_burst();
      chk("R9", "chan_en after exact group", 32'(chan_en), 0);
      chk("R10", "irq masked", 32'(irq), 0);
      cfg_ie = 1'b1;
      cyc(1);
      chk("R10", "irq unmasked", 32'(irq), 1);
      cyc(2);

      cmp_on = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule